// File: doc/BRIEF.md
# Segmented Multiplexed Bus Cycle Controller

This block is a bus master that turns one transfer request into one or two four-state bus cycles on a shared 16-bit address/data bus. A request carries a 16-bit segment, a 16-bit offset, a direction, a memory or I/O space flag, a byte or word size and write data. The controller shifts the segment left by four bits and adds the offset to form a 20-bit physical address. It presents that address with a latch strobe, then releases the shared lines and asserts a read or write strobe. It stretches the cycle while the target holds the ready line low, and it finishes with all strobes released.

Each cycle selects its byte lanes with an active-low high-byte enable and address bit 0. A word request at an odd address is split by the controller into two byte cycles without help from the requester: first the odd byte, then the byte at the next address. A three-bit status code tells observers what kind of cycle is under way. When a request completes, a one-cycle done pulse presents the assembled read data.

Top module: `segbus_master`

## Requirements
- R1: The physical address is (segment × 16 + offset) modulo 2^20. In the first state (T1) of each bus cycle, `bus_a_hi` carries bits 19:16 and `bus_ad_out` carries bits 15:0, with `ale` = 1 and `bus_ad_oe` = 1.
- R2: With `ready` high, a bus cycle lasts exactly four clocks, T1 T2 T3 T4. `ale` is high only in T1. For a read, `rd_n` is low in T2 and T3. For a write, `wr_n` is low in T2 and T3. Both strobes are high in T1 and T4, and the two are never low together.
- R3: Each clock in which `ready` is sampled low, at the end of T3 or of a wait state, adds one wait state. During wait states the active strobe stays low, and the wait states end after the first clock in which `ready` is high.
- R4: Lane select in T1 works as follows. An aligned word drives `bhe_n` = 0 with A0 = 0. A byte at an odd address drives `bhe_n` = 0 with A0 = 1 and uses bits 15:8. A byte at an even address drives `bhe_n` = 1 with A0 = 0 and uses bits 7:0.
- R5: A word request at an odd physical address P runs two back-to-back cycles. The first is at P and carries the low data byte on bits 15:8. The second is at (P+1) modulo 2^20 and carries the high data byte on bits 7:0.
- R6: `status` holds {mem, write, not write} from T1 through T3 and any wait states: 101 for a memory read, 110 for a memory write, 001 for an I/O read and 010 for an I/O write. In T4 and while idle it is 111 (passive).
- R7: `mio` is 1 during a memory cycle and 0 during an I/O cycle.
- R8: Read data is captured from the selected lanes in T4. `done` is high for exactly one clock, the clock after the last T4. At that point `rd_data` holds the assembled value: a full word, {8'h00, byte} for a byte read, or 0 for a write.
- R9: During a write, `bus_ad_oe` = 1 from T2 through T4 and `bus_ad_out` holds the lane-placed data, with the unused lane at 0. During a read, `bus_ad_oe` = 0 from T2 through T4.
- R10: After reset the controller is idle: `busy` = 0, `ale` = 0, `rd_n` = `wr_n` = 1, `bhe_n` = 1, `bus_ad_oe` = 0, `status` = 111 and `done` = 0.
- R11: A request is taken only while `busy` = 0. A `req_valid` pulse during a cycle starts nothing and does not alter the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset value |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_wdata | input | 16 | Write data (byte requests use bits 7:0) |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Assembled read data, valid with done |
| bus_ad_out | output | 16 | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| bus_ad_in | input | 16 | Multiplexed data in |
| bus_a_hi | output | 4 | Address bits 19:16 during T1 |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| mio | output | 1 | Memory (1) or I/O (0) cycle |
| bhe_n | output | 1 | Active-low high-byte enable |
| ready | input | 1 | Target ready, sampled in T3 and wait states |
| status | output | 3 | Cycle status code |

## Verification
The sweep covers every combination of direction, space, size and address parity at zero, one and two wait states. A design that swapped the lanes on odd bytes, or that got the split order wrong, would return its read bytes in the wrong halves. The same fault would put write bytes on the wrong lane. Two requests sit where the segment-plus-offset sum and the split's second address both wrap past 2^20. A controller that failed to truncate either sum would show a wrong T1 address. A request pulse is injected mid-cycle: an eager controller would either start a spurious cycle or corrupt the captured address of the current split.

// File: rtl/segbus_pkg.sv
// Shared types for the segmented bus cycle controller.
// Assumes a single clock domain; state encoding is free for synthesis.
package segbus_pkg;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_T1,
        TS_T2,
        TS_T3,
        TS_TW,
        TS_T4
    } tstate_e;

    localparam logic [2:0] ST_PASSIVE = 3'b111;

    // Status code of an active cycle: space bit, write bit, inverted write bit.
    function automatic logic [2:0] cycle_code(input logic is_mem, input logic is_wr);
        return {is_mem, is_wr, ~is_wr};
    endfunction

endpackage

// File: rtl/segbus_addr_gen.sv
// Physical address former: segment shifted left by SHIFT bits plus offset,
// truncated to the physical width. Also gives the next byte address, which
// is used by the second half of a misaligned word.
// Assumes OFF_W <= SEG_W + SHIFT.
module segbus_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  pa,
    output logic [PA_W-1:0]  pa_next
);

    logic [PA_W:0] sum;

    // Full-width sum; the carry out of the top bit is dropped (wrap).
    always_comb begin
        sum     = {1'b0, seg, {SHIFT{1'b0}}} + {{(PA_W + 1 - OFF_W){1'b0}}, off};
        pa      = sum[PA_W-1:0];
        pa_next = pa + PA_W'(1);
    end

endmodule

// File: rtl/segbus_lane_sel.sv
// Byte-lane steering for one bus cycle. Picks the high-byte enable from the
// cycle size and A0, places outgoing data on the proper lane (the idle lane
// reads 0) and extracts the addressed byte from incoming data.
// Assumes DATA_W is even.
module segbus_lane_sel #(
    parameter int DATA_W = 16,
    localparam int BYTE_W = DATA_W / 2
) (
    input  logic              word_cycle,
    input  logic              a0,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [DATA_W-1:0] full_val,
    input  logic [DATA_W-1:0] bus_in,
    output logic              bhe_n,
    output logic [DATA_W-1:0] drive_data,
    output logic [BYTE_W-1:0] pick_byte
);

    // Lane decode: the upper lane is enabled for whole words and odd bytes.
    always_comb begin
        bhe_n = ~(word_cycle | a0);
        if (word_cycle)
            drive_data = full_val;
        else if (a0)
            drive_data = {byte_val, {BYTE_W{1'b0}}};
        else
            drive_data = {{BYTE_W{1'b0}}, byte_val};
        pick_byte = a0 ? bus_in[DATA_W-1:BYTE_W] : bus_in[BYTE_W-1:0];
    end

endmodule

// File: rtl/segbus_tstate_fsm.sv
// T-state sequencer. Runs T1, T2, T3, optional wait states, T4, and repeats
// once when the request is split into two byte cycles. The part flag tells
// which half of a split is running.
// Assumes start is only raised while idle.
module segbus_tstate_fsm import segbus_pkg::*; (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    ready,
    input  logic    split,
    output tstate_e state,
    output logic    part,
    output logic    last_t4
);

    // Final T4 of a request: either unsplit or second half.
    always_comb last_t4 = (state == TS_T4) && (part || !split);

    // State and part register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TS_IDLE;
            part  <= 1'b0;
        end else begin
            unique case (state)
                TS_IDLE: if (start) begin
                    state <= TS_T1;
                    part  <= 1'b0;
                end
                TS_T1:   state <= TS_T2;
                TS_T2:   state <= TS_T3;
                TS_T3:   state <= ready ? TS_T4 : TS_TW;
                TS_TW:   state <= ready ? TS_T4 : TS_TW;
                TS_T4: begin
                    if (split && !part) begin
                        state <= TS_T1;
                        part  <= 1'b1;
                    end else begin
                        state <= TS_IDLE;
                        part  <= 1'b0;
                    end
                end
                default: state <= TS_IDLE;
            endcase
        end
    end

    AST_T1_THEN_T2: assert property (@(posedge clk) disable iff (!rst_n)
        state == TS_T1 |=> state == TS_T2); // R2
    AST_WAIT_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_T3 && !ready) |=> state == TS_TW); // R3
    AST_SPLIT_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_T4 && split && !part) |=> (state == TS_T1 && part)); // R5

endmodule

// File: rtl/segbus_master.sv
// Bus cycle controller top. Captures a request when idle, forms the physical
// address, sequences one or two four-state cycles on the multiplexed bus,
// steers byte lanes, assembles read data and pulses done at the end.
// Assumes the target keeps read data stable through T4.
module segbus_master import segbus_pkg::*; #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int DATA_W = 16,
    localparam int PA_W   = SEG_W + SHIFT,
    localparam int BYTE_W = DATA_W / 2,
    localparam int HI_W   = PA_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic [HI_W-1:0]   bus_a_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              mio,
    output logic              bhe_n,
    input  logic              ready,
    output logic [2:0]        status
);

    tstate_e           state;
    logic              part, last_t4, start, split, word_cycle;
    logic              strobe_phase, active;
    logic [PA_W-1:0]   pa_now, pa_next_now, r_pa, r_pa2, cur_pa;
    logic              r_wr, r_mem, r_word;
    logic [DATA_W-1:0] r_wdata, r_rdbuf, lane_data;
    logic [BYTE_W-1:0] byte_val, pick_byte;
    logic              lane_bhe_n;

    segbus_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) i_addr (
        .seg     (req_seg),
        .off     (req_off),
        .pa      (pa_now),
        .pa_next (pa_next_now)
    );

    segbus_tstate_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ready   (ready),
        .split   (split),
        .state   (state),
        .part    (part),
        .last_t4 (last_t4)
    );

    segbus_lane_sel #(.DATA_W(DATA_W)) i_lane (
        .word_cycle (word_cycle),
        .a0         (cur_pa[0]),
        .byte_val   (byte_val),
        .full_val   (r_wdata),
        .bus_in     (bus_ad_in),
        .bhe_n      (lane_bhe_n),
        .drive_data (lane_data),
        .pick_byte  (pick_byte)
    );

    // Request acceptance and per-cycle selection of address and data byte.
    always_comb begin
        start        = req_valid && (state == TS_IDLE);
        split        = r_word && r_pa[0];
        word_cycle   = r_word && !r_pa[0];
        cur_pa       = part ? r_pa2 : r_pa;
        byte_val     = (split && part) ? r_wdata[DATA_W-1:BYTE_W] : r_wdata[BYTE_W-1:0];
        active       = (state != TS_IDLE);
        strobe_phase = (state == TS_T2) || (state == TS_T3) || (state == TS_TW);
    end

    // Bus pin drive derived from the T-state and the captured request.
    always_comb begin
        busy      = active;
        ale       = (state == TS_T1);
        rd_n      = !(strobe_phase && !r_wr);
        wr_n      = !(strobe_phase && r_wr);
        bus_ad_oe = ale || (r_wr && (strobe_phase || state == TS_T4));
        if (ale)
            bus_ad_out = cur_pa[DATA_W-1:0];
        else if (bus_ad_oe)
            bus_ad_out = lane_data;
        else
            bus_ad_out = '0;
        bus_a_hi  = ale ? cur_pa[PA_W-1:DATA_W] : '0;
        bhe_n     = active ? lane_bhe_n : 1'b1;
        mio       = active && r_mem;
        status    = (ale || strobe_phase) ? cycle_code(r_mem, r_wr) : ST_PASSIVE;
        rd_data   = r_rdbuf;
    end

    // Request capture on start; cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_pa    <= '0;
            r_pa2   <= '0;
            r_wr    <= 1'b0;
            r_mem   <= 1'b0;
            r_word  <= 1'b0;
            r_wdata <= '0;
        end else if (start) begin
            r_pa    <= pa_now;
            r_pa2   <= pa_next_now;
            r_wr    <= req_write;
            r_mem   <= req_mem;
            r_word  <= req_word;
            r_wdata <= req_wdata;
        end
    end

    // Read data assembly in T4 and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_rdbuf <= '0;
            done    <= 1'b0;
        end else begin
            done <= last_t4;
            if (start)
                r_rdbuf <= '0;
            else if (state == TS_T4 && !r_wr) begin
                if (word_cycle)
                    r_rdbuf <= bus_ad_in;
                else if (split && part)
                    r_rdbuf[DATA_W-1:BYTE_W] <= pick_byte;
                else
                    r_rdbuf[BYTE_W-1:0] <= pick_byte;
            end
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n || wr_n); // R2
    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n)); // R2
    AST_IDLE_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> status == ST_PASSIVE); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> bus_ad_oe); // R1

endmodule

// File: tb/test_segbus_master.sv
module test_segbus_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_seg = '0;
    logic [15:0] req_off = '0;
    logic        req_write = 1'b0;
    logic        req_mem = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [15:0] rd_data, bus_ad_out, bus_ad_in;
    logic        bus_ad_oe, ale, rd_n, wr_n, mio, bhe_n;
    logic [3:0]  bus_a_hi;
    logic        ready = 1'b1;
    logic [2:0]  status;
    logic [19:0] lat = '0;
    logic [19:0] lat_base;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    segbus_master i_segbus_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_off(req_off), .req_write(req_write), .req_mem(req_mem),
        .req_word(req_word), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in), .bus_a_hi(bus_a_hi), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .mio(mio), .bhe_n(bhe_n), .ready(ready), .status(status)
    );

    // Byte stored at a physical address in the bench's target model.
    function automatic logic [7:0] mb(input logic [19:0] x);
        return x[7:0] ^ {x[19:16], x[11:8]} ^ 8'h5A;
    endfunction

    // Target model: latch the address while ale is high, return the even-aligned pair.
    always @(negedge clk) if (ale) lat <= {bus_a_hi, bus_ad_out};
    assign lat_base  = {lat[19:1], 1'b0};
    assign bus_ad_in = {mb(lat_base + 20'd1), mb(lat_base)};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic [15:0] seg, input logic [15:0] off,
                           input logic wr, input logic mem, input logic word,
                           input logic [15:0] wdata, input int waits, input logic poke);
        logic [19:0] pa, pa2, cur;
        logic        split, wc;
        logic        exp_bhe;
        logic [7:0]  bval;
        logic [15:0] exp_wd, exp_rd;
        logic [2:0]  code;
        int          nparts;
        pa     = 20'({seg, 4'h0} + {4'h0, off});
        pa2    = pa + 20'd1;
        split  = word && pa[0];
        wc     = word && !pa[0];
        nparts = split ? 2 : 1;
        code   = {mem, wr, ~wr};
        @(negedge clk);
        req_seg = seg; req_off = off; req_write = wr; req_mem = mem;
        req_word = word; req_wdata = wdata; req_valid = 1'b1; ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int p = 0; p < nparts; p++) begin
            cur     = (p == 1) ? pa2 : pa;
            exp_bhe = !(wc || cur[0]);
            bval    = (split && p == 1) ? wdata[15:8] : wdata[7:0];
            exp_wd  = wc ? wdata : (cur[0] ? {bval, 8'h00} : {8'h00, bval});
            for (int k = 0; k <= 3 + waits; k++) begin
                if (k > 0) @(negedge clk);
                ready = !(k >= 2 && k < 2 + waits);
                if (poke && p == 0 && k == 1) begin
                    req_valid = 1'b1; req_seg = ~seg; req_off = ~off;
                end else if (poke && p == 0 && k == 2) begin
                    req_valid = 1'b0; req_seg = seg; req_off = off;
                end
                if (k == 0) begin
                    chk((p == 1) ? "R5" : "R1", {12'h0, bus_a_hi, bus_ad_out}, {12'h0, cur});
                    chk("R1", {ale, bus_ad_oe}, 2'b11);
                    chk("R4", bhe_n, exp_bhe);
                    chk("R6", status, code);
                    chk("R7", mio, mem);
                end else if (k <= 2 + waits) begin
                    chk((k >= 3) ? "R3" : "R2", {ale, rd_n, wr_n}, {1'b0, wr, !wr});
                    chk("R6", status, code);
                    if (wr) chk(split ? "R5" : "R9", {bus_ad_oe, bus_ad_out}, {1'b1, exp_wd});
                    else    chk("R9", bus_ad_oe, 1'b0);
                end else begin
                    chk("R2", {ale, rd_n, wr_n}, 3'b011);
                    chk("R6", status, 3'b111);
                    if (wr) chk("R9", {bus_ad_oe, bus_ad_out}, {1'b1, exp_wd});
                    else    chk("R9", bus_ad_oe, 1'b0);
                end
            end
            @(negedge clk);
        end
        ready = 1'b1;
        if (wr)        exp_rd = 16'h0;
        else if (word) exp_rd = {mb(pa2), mb(pa)};
        else           exp_rd = {8'h00, mb(pa)};
        chk("R8", done, 1'b1);
        chk("R8", rd_data, exp_rd);
        @(negedge clk);
        chk("R8", {done, busy}, 2'b00);
        if (poke) begin
            @(negedge clk);
            chk("R11", {ale, busy}, 2'b00);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", {busy, ale, rd_n, wr_n, bhe_n, bus_ad_oe, done}, 7'b0011100);
        chk("R10", status, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", {busy, ale, rd_n, wr_n, status}, {4'b0011, 3'b111});
        for (int i = 0; i < 48; i++) begin
            logic [15:0] s, o;
            s = 16'h1234 + 16'(i) * 16'h0111;
            o = 16'h0200 + 16'(i) * 16'h0137;
            o[0] = i[3];
            run_req(s, o, i[0], i[1], i[2], 16'hC3A0 ^ 16'(i * 16'h0923), i / 16, 1'b0);
        end
        // R1 wrap of the segment/offset sum, R5 wrap of the split's second address
        run_req(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b1, 16'h0, 0, 1'b0);
        run_req(16'hF000, 16'hFFFF, 1'b0, 1'b1, 1'b1, 16'h0, 1, 1'b0);
        run_req(16'hF000, 16'hFFFF, 1'b1, 1'b1, 1'b1, 16'hBEEF, 0, 1'b0);
        // R11: request pulse during a split cycle is ignored
        run_req(16'h0ABC, 16'h0011, 1'b0, 1'b0, 1'b1, 16'h0, 2, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule